// File: doc/BRIEF.md
# Bit-Serial Two-Wire Bus Engine

This block moves one bit at a time over the open-drain clock and data wires of an I2C bus. It can act as master or slave, sending or receiving. Both wires pass through a sample-majority filter. The filtered levels drive several functions: detection of START and STOP conditions, a bus-busy indication, a start interrupt, and latching of each received bit. Byte assembly, address matching, acknowledge handling and the issuing of START or STOP stay with software. Software sees a single-bit data register and a handful of flags.

When a clock pulse completes, meaning a rising and then a falling clock edge, the block holds the clock wire low. This suspends the bus until software either releases it or writes the next bit. A bit that is being sent is checked against the wire level at the clock's rising edge, which detects arbitration loss. In master mode, writing the bit register starts a clock pulse that the block generates itself. The low and high phases last a programmable number of system clocks. The block does not count the high phase until the wire actually reads high, so a slave that stretches the clock delays the pulse.

Each wire is an input level plus a "pull low" output. The pad's open-drain driver is outside the block.

Top module: `i2cb_core`

## Requirements
- R1: Each wire is filtered by a 3-sample majority vote taken on the system clock. A level that lasts one sample only has no effect on any flag or output. A level held on the wire is first sampled at edge k, reaches the filtered value at edge k+2 and reaches the flags at edge k+3.
- R2: A START is the filtered data falling while the filtered clock is high. It sets `bus_busy`. A STOP is the filtered data rising while the filtered clock is high. It clears `bus_busy`.
- R3: The first filtered clock fall after a START sets `start_irq`. The flag stays set until an `irq_ack` pulse clears it.
- R4: On each filtered clock rise, `rx_bit` takes the filtered data level.
- R5: A filtered clock rise sets `clk_rise_seen`.
- R6: A filtered clock fall while `clk_rise_seen` is set completes a pulse. It sets `rd_done` and makes `scl_drive_low` hold the clock wire low.
- R7: On a completed pulse, `wr_done` is set only if no arbitration loss was seen at that pulse's rise. Arbitration loss means the sent bit was 1 while the filtered data read 0.
- R8: A `sw_release` pulse or a `bit_wr` pulse clears `clk_rise_seen`, `rd_done` and `wr_done` and releases the held clock. A set event in the same cycle takes precedence over the clear.
- R9: `bit_wr` loads `bit_wdata` into the sent bit. `sda_drive_low` is the inverse of the sent bit, and the sent bit is 1 after reset.
- R10: With `master_mode` at 1, `bit_wr` starts an automatic pulse. The block pulls the clock low for `lo_cycles` clocks, or 1 clock if the count is 0. It then releases the wire and, once the wire reads high, waits `hi_cycles` clocks. It then pulls the clock low until the filtered fall is seen.
- R11: During the automatic pulse, the high-phase count does not start while another device holds the clock low.
- R12: After reset every flag is 0, `rx_bit` is 0 and neither wire is pulled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Clock wire level |
| sda_i | input | 1 | Data wire level |
| scl_drive_low | output | 1 | Pull the clock wire low |
| sda_drive_low | output | 1 | Pull the data wire low |
| master_mode | input | 1 | Enables the automatic clock on bit writes |
| lo_cycles | input | CW | Low-phase length of the automatic clock |
| hi_cycles | input | CW | High-phase length of the automatic clock |
| bit_wr | input | 1 | Write strobe of the single-bit data register |
| bit_wdata | input | 1 | Bit to send |
| sw_release | input | 1 | Release the held clock and clear the bit flags |
| irq_ack | input | 1 | Clears the start interrupt |
| rx_bit | output | 1 | Last received bit |
| bus_busy | output | 1 | Bus occupied between START and STOP |
| start_irq | output | 1 | Start interrupt request |
| clk_rise_seen | output | 1 | Clock rise detected |
| rd_done | output | 1 | Read bit finished |
| wr_done | output | 1 | Write bit finished without arbitration loss |

## Verification
A wire change first sampled at edge k shows in the flags only after edge k+3. Strobes such as `bit_wr`, `sw_release` and `irq_ack` act at the first edge that samples them. The automatic clock's pull-low output follows its phase counters with no added delay. The bench carries a behavioural model that advances at each rising edge, using the wire levels and strobes captured just before that edge. It compares every output with the model 2 ns after each falling edge, when all registers have settled. The scenarios add targeted checks where the order of events matters: glitches, arbitration, clock stretching and release.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;

  typedef enum logic [2:0] {
    AC_IDLE   = 3'd0,
    AC_LOW    = 3'd1,
    AC_WAITHI = 3'd2,
    AC_HIGH   = 3'd3,
    AC_TAIL   = 3'd4
  } autoclk_e;

  typedef struct packed {
    logic rise;
    logic fall;
    logic start;
    logic stop;
  } bus_evt_t;

endpackage

// File: rtl/i2cb_glitch_filter.sv
module i2cb_glitch_filter #(
  parameter int TAPS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic filt
);
  localparam int OW = $clog2(TAPS + 1);
  localparam logic [OW-1:0] HALF = OW'(TAPS / 2);

  logic [TAPS-1:0] shr, shr_nxt;
  logic [OW-1:0]   ones;
  logic            filt_nxt;

  always_comb begin
    shr_nxt = {shr[TAPS-2:0], raw};
    ones = '0;
    for (int i = 0; i < TAPS; i++) begin
      ones = ones + OW'(shr[i]);
    end
    filt_nxt = (ones > HALF);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shr  <= '1;
      filt <= 1'b1;
    end else begin
      shr  <= shr_nxt;
      filt <= filt_nxt;
    end
  end

  AST_FILT_NEEDS_TWO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(filt) |-> (!$past(raw, 1) || !$past(raw, 2))); // R1

endmodule

// File: rtl/i2cb_cond_detect.sv
module i2cb_cond_detect
  import i2cb_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     f_scl,
  input  logic     f_sda,
  output bus_evt_t evt
);
  logic scl_q, sda_q;

  always_comb begin
    evt.rise  = f_scl & ~scl_q;
    evt.fall  = ~f_scl & scl_q;
    evt.start = f_scl & scl_q & ~f_sda & sda_q;
    evt.stop  = f_scl & scl_q & f_sda & ~sda_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= f_scl;
      sda_q <= f_sda;
    end
  end

endmodule

// File: rtl/i2cb_flags.sv
module i2cb_flags
  import i2cb_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  bus_evt_t evt,
  input  logic     f_sda,
  input  logic     tx_bit,
  input  logic     clr,
  input  logic     irq_ack,
  output logic     rx_bit,
  output logic     bus_busy,
  output logic     start_irq,
  output logic     clh,
  output logic     rbf,
  output logic     wbf,
  output logic     hold
);
  logic pend, lost;
  logic n_rx, n_busy, n_irq, n_clh, n_rbf, n_wbf, n_hold, n_pend, n_lost;
  logic pulse_end;

  always_comb begin
    pulse_end = evt.fall & clh;
    n_clh  = evt.rise ? 1'b1 : (clr ? 1'b0 : clh);
    n_rbf  = pulse_end ? 1'b1 : (clr ? 1'b0 : rbf);
    n_wbf  = pulse_end ? ~lost : (clr ? 1'b0 : wbf);
    n_hold = pulse_end ? 1'b1 : (clr ? 1'b0 : hold);
    n_lost = evt.rise ? (tx_bit & ~f_sda) : (clr ? 1'b0 : lost);
    n_rx   = evt.rise ? f_sda : rx_bit;
    n_busy = evt.start ? 1'b1 : (evt.stop ? 1'b0 : bus_busy);
    n_pend = evt.start ? 1'b1 : (evt.fall ? 1'b0 : pend);
    n_irq  = (evt.fall & pend) ? 1'b1 : (irq_ack ? 1'b0 : start_irq);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_bit    <= 1'b0;
      bus_busy  <= 1'b0;
      start_irq <= 1'b0;
      clh       <= 1'b0;
      rbf       <= 1'b0;
      wbf       <= 1'b0;
      hold      <= 1'b0;
      pend      <= 1'b0;
      lost      <= 1'b0;
    end else begin
      rx_bit    <= n_rx;
      bus_busy  <= n_busy;
      start_irq <= n_irq;
      clh       <= n_clh;
      rbf       <= n_rbf;
      wbf       <= n_wbf;
      hold      <= n_hold;
      pend      <= n_pend;
      lost      <= n_lost;
    end
  end

  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    evt.start |=> bus_busy); // R2
  AST_IRQ_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_irq) |-> $past(evt.fall)); // R3
  AST_HOLD_ON_PULSE_END: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.fall && clh) |=> (hold && rbf)); // R6
  AST_WBF_NEEDS_RBF: assert property (@(posedge clk) disable iff (!rst_n)
    wbf |-> rbf); // R7

endmodule

// File: rtl/i2cb_autoclk.sv
module i2cb_autoclk
  import i2cb_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          scl_high,
  input  logic          scl_fall,
  input  logic [CW-1:0] lo_cycles,
  input  logic [CW-1:0] hi_cycles,
  output logic          drive_low
);
  autoclk_e      state, state_nxt;
  logic [CW-1:0] cnt, cnt_nxt;
  logic [CW:0]   cnt_inc;

  always_comb begin
    state_nxt = state;
    cnt_nxt   = cnt;
    cnt_inc   = {1'b0, cnt} + 1'b1;
    case (state)
      AC_IDLE: begin
        if (go) begin
          state_nxt = AC_LOW;
          cnt_nxt   = '0;
        end
      end
      AC_LOW: begin
        if (cnt_inc >= {1'b0, lo_cycles}) begin
          state_nxt = AC_WAITHI;
          cnt_nxt   = '0;
        end else begin
          cnt_nxt = cnt_inc[CW-1:0];
        end
      end
      AC_WAITHI: begin
        if (scl_high) begin
          state_nxt = AC_HIGH;
          cnt_nxt   = '0;
        end
      end
      AC_HIGH: begin
        if (cnt_inc >= {1'b0, hi_cycles}) begin
          state_nxt = AC_TAIL;
          cnt_nxt   = '0;
        end else begin
          cnt_nxt = cnt_inc[CW-1:0];
        end
      end
      AC_TAIL: begin
        if (scl_fall) state_nxt = AC_IDLE;
      end
      default: state_nxt = AC_IDLE;
    endcase
  end

  assign drive_low = (state == AC_LOW) || (state == AC_TAIL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= AC_IDLE;
      cnt   <= '0;
    end else begin
      state <= state_nxt;
      cnt   <= cnt_nxt;
    end
  end

  AST_WAIT_FOR_WIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == AC_WAITHI && !scl_high) |=> (state == AC_WAITHI)); // R11
  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state == AC_IDLE && go) |=> drive_low); // R10

endmodule

// File: rtl/i2cb_core.sv
module i2cb_core
  import i2cb_pkg::*;
#(
  parameter int TAPS = 3,
  parameter int CW   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_drive_low,
  output logic          sda_drive_low,
  input  logic          master_mode,
  input  logic [CW-1:0] lo_cycles,
  input  logic [CW-1:0] hi_cycles,
  input  logic          bit_wr,
  input  logic          bit_wdata,
  input  logic          sw_release,
  input  logic          irq_ack,
  output logic          rx_bit,
  output logic          bus_busy,
  output logic          start_irq,
  output logic          clk_rise_seen,
  output logic          rd_done,
  output logic          wr_done
);
  localparam int NLINE = 2;
  localparam int SCL_IX = 0;
  localparam int SDA_IX = 1;

  logic [NLINE-1:0] raw_v, filt_v;
  bus_evt_t         evt;
  logic             tx_bit, tx_nxt;
  logic             hold, auto_low;

  assign raw_v = {sda_i, scl_i};

  for (genvar g = 0; g < NLINE; g++) begin : g_line
    i2cb_glitch_filter #(.TAPS(TAPS)) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .raw  (raw_v[g]),
      .filt (filt_v[g])
    );
  end

  i2cb_cond_detect u_det (
    .clk  (clk),
    .rst_n(rst_n),
    .f_scl(filt_v[SCL_IX]),
    .f_sda(filt_v[SDA_IX]),
    .evt  (evt)
  );

  i2cb_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt),
    .f_sda    (filt_v[SDA_IX]),
    .tx_bit   (tx_bit),
    .clr      (sw_release | bit_wr),
    .irq_ack  (irq_ack),
    .rx_bit   (rx_bit),
    .bus_busy (bus_busy),
    .start_irq(start_irq),
    .clh      (clk_rise_seen),
    .rbf      (rd_done),
    .wbf      (wr_done),
    .hold     (hold)
  );

  i2cb_autoclk #(.CW(CW)) u_auto (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (bit_wr & master_mode),
    .scl_high (filt_v[SCL_IX]),
    .scl_fall (evt.fall),
    .lo_cycles(lo_cycles),
    .hi_cycles(hi_cycles),
    .drive_low(auto_low)
  );

  always_comb begin
    tx_nxt = bit_wr ? bit_wdata : tx_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_bit <= 1'b1;
    else        tx_bit <= tx_nxt;
  end

  assign scl_drive_low = hold | auto_low;
  assign sda_drive_low = ~tx_bit;

  AST_SDA_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_wr |=> (sda_drive_low == !$past(bit_wdata))); // R9
  AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_release && !bit_wr && !master_mode && !evt.rise && !evt.fall)
      |=> (!rd_done && !wr_done && !clk_rise_seen && !scl_drive_low)); // R8

endmodule

// File: tb/i2cb_core_test.sv
module i2cb_core_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       ext_scl_low = 1'b0, ext_sda_low = 1'b0;
  logic       b_wr = 0, b_wd = 0, b_rel = 0, b_ack = 0, b_mm = 0;
  logic [7:0] lo = 8'd3, hi = 8'd4;
  logic       scl_drive_low, sda_drive_low, rx_bit, bus_busy, start_irq;
  logic       clk_rise_seen, rd_done, wr_done;

  wire scl_line = !(scl_drive_low | ext_scl_low);
  wire sda_line = !(sda_drive_low | ext_sda_low);

  i2cb_core uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
    .master_mode(b_mm), .lo_cycles(lo), .hi_cycles(hi),
    .bit_wr(b_wr), .bit_wdata(b_wd), .sw_release(b_rel), .irq_ack(b_ack),
    .rx_bit(rx_bit), .bus_busy(bus_busy), .start_irq(start_irq),
    .clk_rise_seen(clk_rise_seen), .rd_done(rd_done), .wr_done(wr_done));

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit c_scl, c_sda, c_wr, c_wd, c_rel, c_ack, c_mm;
  bit hq_scl[$], hq_sda[$];
  bit m_fc, m_fs, m_fcd, m_fsd;
  bit m_rx, m_busy, m_irq, m_clh, m_rbf, m_wbf, m_hold, m_pend, m_lost, m_tx;
  int m_ast, m_acnt;
  bit e_rise, e_fall, e_st, e_sp, e_clr, e_end;
  int n_ast, n_acnt, ones_c, ones_s;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hq_scl = '{1, 1, 1}; hq_sda = '{1, 1, 1};
      m_fc = 1; m_fs = 1; m_fcd = 1; m_fsd = 1;
      m_rx = 0; m_busy = 0; m_irq = 0; m_clh = 0; m_rbf = 0; m_wbf = 0;
      m_hold = 0; m_pend = 0; m_lost = 0; m_tx = 1; m_ast = 0; m_acnt = 0;
    end else begin
      e_rise = m_fc && !m_fcd;
      e_fall = !m_fc && m_fcd;
      e_st = m_fc && m_fcd && !m_fs && m_fsd;
      e_sp = m_fc && m_fcd && m_fs && !m_fsd;
      e_clr = c_rel || c_wr;
      e_end = e_fall && m_clh;
      n_ast = m_ast; n_acnt = m_acnt;
      case (m_ast)
        0: if (c_wr && c_mm) begin n_ast = 1; n_acnt = 0; end
        1: if (m_acnt + 1 >= int'(lo)) begin n_ast = 2; n_acnt = 0; end else n_acnt = m_acnt + 1;
        2: if (m_fc) begin n_ast = 3; n_acnt = 0; end
        3: if (m_acnt + 1 >= int'(hi)) begin n_ast = 4; n_acnt = 0; end else n_acnt = m_acnt + 1;
        default: if (e_fall) n_ast = 0;
      endcase
      m_ast = n_ast; m_acnt = n_acnt;
      if (e_end) begin m_rbf = 1; m_wbf = !m_lost; m_hold = 1; end
      else if (e_clr) begin m_rbf = 0; m_wbf = 0; m_hold = 0; end
      if (e_rise) begin m_lost = m_tx && !m_fs; m_rx = m_fs; end
      else if (e_clr) m_lost = 0;
      if (e_rise) m_clh = 1; else if (e_clr) m_clh = 0;
      if (e_st) m_busy = 1; else if (e_sp) m_busy = 0;
      if (e_fall && m_pend) m_irq = 1; else if (c_ack) m_irq = 0;
      if (e_st) m_pend = 1; else if (e_fall) m_pend = 0;
      if (c_wr) m_tx = c_wd;
      m_fcd = m_fc; m_fsd = m_fs;
      ones_c = 0; ones_s = 0;
      foreach (hq_scl[i]) ones_c += hq_scl[i];
      foreach (hq_sda[i]) ones_s += hq_sda[i];
      m_fc = (ones_c >= 2); m_fs = (ones_s >= 2);
      hq_scl.push_front(c_scl); void'(hq_scl.pop_back());
      hq_sda.push_front(c_sda); void'(hq_sda.pop_back());
    end
  end

  // compare every cycle after registers settle, then capture pre-edge inputs
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk("R4 rx_bit", rx_bit, m_rx);
      chk("R2 bus_busy", bus_busy, m_busy);
      chk("R3 start_irq", start_irq, m_irq);
      chk("R5 clk_rise_seen", clk_rise_seen, m_clh);
      chk("R6 rd_done", rd_done, m_rbf);
      chk("R7 wr_done", wr_done, m_wbf);
      chk("R10 scl_drive_low", scl_drive_low, m_hold || m_ast == 1 || m_ast == 4);
      chk("R9 sda_drive_low", sda_drive_low, !m_tx);
    end
    c_scl = scl_line; c_sda = sda_line;
    c_wr = b_wr; c_wd = b_wd; c_rel = b_rel; c_ack = b_ack; c_mm = b_mm;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_rel();
    b_rel = 1; cyc(1); b_rel = 0; cyc(2);
  endtask

  task automatic write_bit(input logic v);
    b_wd = v; b_wr = 1; cyc(1); b_wr = 0; cyc(3);
  endtask

  task automatic ext_bit(input logic v);
    ext_sda_low = !v; cyc(4);
    ext_scl_low = 0; cyc(8);
    ext_scl_low = 1; cyc(8);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(2);
    // R12 reset state
    chk("R12 reset rd_done", rd_done, 0);
    chk("R12 reset bus_busy", bus_busy, 0);
    chk("R12 reset scl_drive_low", scl_drive_low, 0);
    chk("R12 reset sda_drive_low", sda_drive_low, 0);
    cyc(4);
    // R1 single-sample glitch on data while clock high: no START
    ext_sda_low = 1; cyc(1); ext_sda_low = 0; cyc(8);
    chk("R1 glitch ignored bus_busy", bus_busy, 0);
    // START then first clock fall
    ext_sda_low = 1; cyc(8);
    chk("R2 start sets busy", bus_busy, 1);
    ext_scl_low = 1; cyc(8);
    chk("R3 irq after first fall", start_irq, 1);
    b_ack = 1; cyc(1); b_ack = 0; cyc(2);
    chk("R3 irq cleared by ack", start_irq, 0);
    // slave receive 1,0,1
    ext_bit(1);
    chk("R4 rx bit 1", rx_bit, 1);
    chk("R6 pulse done rd_done", rd_done, 1);
    chk("R6 clock held", scl_drive_low, 1);
    pulse_rel();
    chk("R8 release clears rd_done", rd_done, 0);
    chk("R8 release frees clock", scl_drive_low, 0);
    ext_bit(0);
    chk("R4 rx bit 0", rx_bit, 0);
    pulse_rel();
    // arbitration: send 1, other device drives 0
    write_bit(1);
    ext_bit(0);
    chk("R7 arbitration loss wr_done", wr_done, 0);
    chk("R7 rd_done still set", rd_done, 1);
    write_bit(0);
    chk("R9 sends 0", sda_drive_low, 1);
    chk("R8 bit write clears rd_done", rd_done, 0);
    ext_bit(0);
    chk("R7 no loss wr_done", wr_done, 1);
    write_bit(1);
    ext_bit(1);
    chk("R7 send 1 ok", wr_done, 1);
    chk("R4 rx 1 again", rx_bit, 1);
    // STOP
    ext_sda_low = 1; pulse_rel(); ext_scl_low = 0; cyc(8);
    ext_sda_low = 0; cyc(8);
    chk("R2 stop clears busy", bus_busy, 0);
    // R1 clock glitch while clk_rise_seen set: no pulse completes
    ext_scl_low = 1; cyc(1); ext_scl_low = 0; cyc(8);
    chk("R1 clock glitch ignored", rd_done, 0);
    // master automatic pulse
    b_mm = 1;
    write_bit(1);
    cyc(30);
    chk("R10 auto pulse done", rd_done, 1);
    chk("R10 auto clock ends held", scl_drive_low, 1);
    chk("R10 auto pulse no loss", wr_done, 1);
    // master with slave stretching
    lo = 8'd0; hi = 8'd6;
    b_wd = 0; b_wr = 1; cyc(1); b_wr = 0; ext_scl_low = 1;
    cyc(15);
    chk("R11 own drive released while stretched", scl_drive_low, 0);
    chk("R11 no pulse during stretch", rd_done, 0);
    ext_scl_low = 0; cyc(4);
    chk("R11 high phase running", clk_rise_seen, 1);
    cyc(30);
    chk("R11 pulse after stretch", rd_done, 1);
    b_mm = 0;
    write_bit(1);
    cyc(4);
    finish_run();
  end
endmodule